// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible face of a byte-oriented serial port that follows the long-established 16550 register programming model. It sits between a simple 32-bit bus with word addresses and a UART core. Eight byte-wide registers are decoded, and each one occupies its own 32-bit word. The serial shifter, the baud generator and the FIFO storage live in the core. This block holds the configuration the core needs: a 16-bit baud divisor, the line format, modem-control bits and FIFO options. It turns bus accesses into single-cycle transmit-push, receive-pop and FIFO-clear strobes, and it reports the core's status back to software.

The line-control bit 7 is the divisor-access switch. While it is set, the data word and the interrupt-enable word map onto the low and high bytes of the divisor. While it is clear, the data word moves bytes to and from the core. An interrupt line combines four sources: receive data, transmit holding empty, receive line errors and modem status. Each source has its own enable bit. A prioritised identification code tells software which source to service first.

Top module: `uart_reg_front`

## Requirements
- R1: The scratch word (offset 7) stores any written byte and returns it unchanged. The modem-control word (offset 4) stores bits 4:0, reads them back with bits 7:5 as zero, and drives them on `modem_ctl`.
- R2: While `line_ctl[7]` is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The divisor appears on `divisor` in the cycle after the write.
- R3: While `line_ctl[7]` is 0, a write to offset 0 places wdata[7:0] on `tx_data` and raises `tx_push` for exactly one cycle, one cycle after the write. The divisor does not change.
- R4: While `line_ctl[7]` is 0, a read of offset 0 with `rx_avail` high returns `rx_data` and raises `rx_pop` for one cycle. With `rx_avail` low, the read returns 0 and no pop occurs.
- R5: Interrupt-enable bits 3:0 (offset 1, divisor access closed) enable, in order, receive-data, transmit-empty, line-error and modem-status interrupts. Bits 7:4 read as 0. `irq` is the registered OR of each enabled source with its pending condition: `rx_avail`, `tx_empty`, any `line_err` bit, and any of `modem_in[3:0]`. `irq` follows one cycle after its inputs change.
- R6: The line-status word (offset 5) reads as follows: bit 0 is `rx_avail`, bits 4:1 are `line_err[3:0]`, bit 5 is `tx_empty`, bit 6 is `tx_empty & tx_idle`, and bit 7 is the OR of `line_err`.
- R7: A write to offset 2 stores bit 0 as `fifo_en` and bit 5 as `fifo_deep`. Bits 1 and 2 each produce a one-cycle pulse on `rx_clr` and `tx_clr`, and these bits are not stored.
- R8: Writes to offset 5 (line status) and offset 6 (modem status) have no effect. Offset 6 reads back `modem_in` directly.
- R9: Reset clears interrupt enable, line control, modem control, scratch and the FIFO options, clears `irq`, and sets the divisor to 1.
- R10: A read of offset 2 returns {fifo_en, fifo_en, 2'b00, id}. The id is 0x6 for an enabled line error, then 0x4 for enabled receive data, 0x2 for enabled transmit empty, 0x0 for enabled modem status, and 0x1 when nothing is pending, in that priority order.
- R11: Line control (offset 3) stores all 8 bits, reads back the stored value, and drives it on `line_ctl`. The value 0x83 opens divisor access and 0x03 closes it, leaving the format bits at 0x03.
- R12: Each read returns its byte zero-extended on `bus_rdata`, with `rd_valid` high, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data (bits 7:0 used) |
| bus_rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| tx_data | output | 8 | Byte handed to the core |
| tx_push | output | 1 | One-cycle transmit push |
| rx_data | input | 8 | Head byte from the core |
| rx_avail | input | 1 | Core holds at least one received byte |
| rx_pop | output | 1 | One-cycle receive pop |
| tx_empty | input | 1 | Transmit holding buffer empty |
| tx_idle | input | 1 | Shifter idle |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| modem_in | input | 8 | Modem status from pins/core |
| divisor | output | 16 | Baud divisor |
| line_ctl | output | 8 | Line control value |
| modem_ctl | output | 5 | Modem control bits |
| fifo_en | output | 1 | FIFO enable |
| fifo_deep | output | 1 | Deep FIFO request |
| rx_clr | output | 1 | Receive FIFO clear pulse |
| tx_clr | output | 1 | Transmit FIFO clear pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the identification priority with several sources pending at once. Lower-priority codes are hidden until every higher source is withdrawn. The stimulus therefore enables all four sources, raises every pending input, and then removes them one at a time from the top of the priority order, reading the identification word after each step. A second hard case is aliasing: the same offset must push a byte with divisor access closed and load the divisor with it open. This is reached by writing 0x83 and 0x03 to line control around the data-word accesses, and by checking that the divisor stays unchanged across a transmit push.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int REG_W  = 8;
  localparam int IDX_W  = 3;
  localparam int NREGS  = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IX_DATA = 3'd0;
  localparam logic [IDX_W-1:0] IX_IEN  = 3'd1;
  localparam logic [IDX_W-1:0] IX_IDF  = 3'd2;
  localparam logic [IDX_W-1:0] IX_LCTL = 3'd3;
  localparam logic [IDX_W-1:0] IX_MCTL = 3'd4;
  localparam logic [IDX_W-1:0] IX_LSTS = 3'd5;
  localparam logic [IDX_W-1:0] IX_MSTS = 3'd6;
  localparam logic [IDX_W-1:0] IX_SCR  = 3'd7;

  typedef struct packed {
    logic div_lo;
    logic div_hi;
    logic tx;
    logic ien;
    logic fctl;
    logic lctl;
    logic mctl;
    logic scr;
  } wr_sel_t;

  localparam int SRC_N = 4;
  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LERR = 4'h6;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_TXE  = 4'h2;
  localparam logic [3:0] ID_MSTS = 4'h0;
endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
  import uart_regs_pkg::*;
(
  input  logic             req,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             dlab,
  output wr_sel_t          wsel,
  output logic             rd_data_pop
);
  always_comb begin
    wsel = '0;
    if (req && we) begin
      unique case (idx)
        IX_DATA: begin
          wsel.div_lo = dlab;
          wsel.tx     = !dlab;
        end
        IX_IEN: begin
          wsel.div_hi = dlab;
          wsel.ien    = !dlab;
        end
        IX_IDF:  wsel.fctl = 1'b1;
        IX_LCTL: wsel.lctl = 1'b1;
        IX_MCTL: wsel.mctl = 1'b1;
        IX_SCR:  wsel.scr  = 1'b1;
        default: ;
      endcase
    end
  end

  assign rd_data_pop = req && !we && (idx == IX_DATA) && !dlab;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regs_pkg::*;
(
  input  logic [SRC_N-1:0] enable,
  input  logic             rx_pend,
  input  logic             tx_pend,
  input  logic             err_pend,
  input  logic             ms_pend,
  output logic [3:0]       id,
  output logic             any
);
  logic [SRC_N-1:0] act;

  assign act = enable & {ms_pend, err_pend, tx_pend, rx_pend};
  assign any = |act;

  always_comb begin
    if (act[2])      id = ID_LERR;
    else if (act[0]) id = ID_RXD;
    else if (act[1]) id = ID_TXE;
    else if (act[3]) id = ID_MSTS;
    else             id = ID_NONE;
  end
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_regs_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int DIV_W   = 16,
  parameter int MCTL_W  = 5,
  parameter int ERR_W   = 4,
  parameter int DIV_RST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              rd_valid,
  output logic [REG_W-1:0]  tx_data,
  output logic              tx_push,
  input  logic [REG_W-1:0]  rx_data,
  input  logic              rx_avail,
  output logic              rx_pop,
  input  logic              tx_empty,
  input  logic              tx_idle,
  input  logic [ERR_W-1:0]  line_err,
  input  logic [REG_W-1:0]  modem_in,
  output logic [DIV_W-1:0]  divisor,
  output logic [REG_W-1:0]  line_ctl,
  output logic [MCTL_W-1:0] modem_ctl,
  output logic              fifo_en,
  output logic              fifo_deep,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic              irq
);
  localparam int DIV_BYTES = DIV_W / REG_W;
  localparam int PAD_W     = BUS_W - REG_W;
  localparam int DLAB_BIT  = REG_W - 1;

  wr_sel_t          wsel;
  logic             pop_req;
  logic [SRC_N-1:0] ier_q;
  logic [REG_W-1:0] scr_q;
  logic [3:0]       iid;
  logic             irq_any;
  logic [REG_W-1:0] rd_byte;
  logic [REG_W-1:0] lsts;
  logic [REG_W-1:0] wbyte;
  logic             dlab;

  assign wbyte = bus_wdata[REG_W-1:0];
  assign dlab  = line_ctl[DLAB_BIT];

  uart_addr_decode u_dec (
    .req         (bus_req),
    .we          (bus_we),
    .idx         (bus_addr),
    .dlab        (dlab),
    .wsel        (wsel),
    .rd_data_pop (pop_req)
  );

  uart_irq_prio u_irq (
    .enable   (ier_q),
    .rx_pend  (rx_avail),
    .tx_pend  (tx_empty),
    .err_pend (|line_err),
    .ms_pend  (|modem_in[3:0]),
    .id       (iid),
    .any      (irq_any)
  );

  // Divisor bytes, one register per byte lane.
  generate
    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
      logic sel;
      if (b == 0) begin : g_lo
        assign sel = wsel.div_lo;
      end else begin : g_hi
        assign sel = wsel.div_hi;
      end
      always_ff @(posedge clk) begin
        if (rst)
          divisor[b*REG_W +: REG_W] <= REG_W'(DIV_RST >> (b*REG_W));
        else if (sel)
          divisor[b*REG_W +: REG_W] <= wbyte;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q     <= '0;
      line_ctl  <= '0;
      modem_ctl <= '0;
      scr_q     <= '0;
      fifo_en   <= 1'b0;
      fifo_deep <= 1'b0;
    end else begin
      if (wsel.ien)  ier_q     <= wbyte[SRC_N-1:0];
      if (wsel.lctl) line_ctl  <= wbyte;
      if (wsel.mctl) modem_ctl <= wbyte[MCTL_W-1:0];
      if (wsel.scr)  scr_q     <= wbyte;
      if (wsel.fctl) begin
        fifo_en   <= wbyte[0];
        fifo_deep <= wbyte[5];
      end
    end
  end

  // Strobes: registered one-cycle pulses.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push <= 1'b0;
      tx_data <= '0;
      rx_clr  <= 1'b0;
      tx_clr  <= 1'b0;
      rx_pop  <= 1'b0;
    end else begin
      tx_push <= wsel.tx;
      if (wsel.tx) tx_data <= wbyte;
      rx_clr  <= wsel.fctl && wbyte[1];
      tx_clr  <= wsel.fctl && wbyte[2];
      rx_pop  <= pop_req && rx_avail;
    end
  end

  assign lsts = {|line_err, tx_empty & tx_idle, tx_empty, line_err, rx_avail};

  always_comb begin
    unique case (bus_addr)
      IX_DATA: rd_byte = dlab ? divisor[REG_W-1:0] : (rx_avail ? rx_data : '0);
      IX_IEN:  rd_byte = dlab ? divisor[2*REG_W-1:REG_W] : REG_W'(ier_q);
      IX_IDF:  rd_byte = {fifo_en, fifo_en, 2'b00, iid};
      IX_LCTL: rd_byte = line_ctl;
      IX_MCTL: rd_byte = REG_W'(modem_ctl);
      IX_LSTS: rd_byte = lsts;
      IX_MSTS: rd_byte = modem_in;
      default: rd_byte = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      rd_valid <= bus_req && !bus_we;
      if (bus_req && !bus_we) bus_rdata <= {{PAD_W{1'b0}}, rd_byte};
      irq <= irq_any;
    end
  end
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk
  import uart_regs_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_we,
  input logic [IDX_W-1:0] bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             rx_avail,
  input logic             tx_push,
  input logic             rx_pop,
  input logic             rx_clr,
  input logic             tx_clr,
  input logic [15:0]      divisor,
  input logic [7:0]       line_ctl,
  input logic             rd_valid,
  input logic             irq
);
  logic wr_div;
  assign wr_div = bus_req && bus_we && line_ctl[7] &&
                  (bus_addr == IX_DATA || bus_addr == IX_IEN);

  // R3
  p_push_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(bus_req && bus_we && bus_addr == IX_DATA && !line_ctl[7]));
  // R2
  p_div_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_div) |-> $stable(divisor));
  // R4
  p_pop_needs_data_r4: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> ($past(rx_avail) && rd_valid));
  // R7
  p_rxclr_src_r7: assert property (@(posedge clk) disable iff (rst)
    rx_clr |-> $past(bus_req && bus_we && bus_addr == IX_IDF && bus_wdata[1]));
  p_txclr_src_r7: assert property (@(posedge clk) disable iff (rst)
    tx_clr |-> $past(bus_req && bus_we && bus_addr == IX_IDF && bus_wdata[2]));
  // R12
  p_rdvalid_r12: assert property (@(posedge clk) disable iff (rst)
    $past(bus_req && !bus_we) |-> rd_valid);
  // R9
  p_rst_irq_r9: assert property (@(posedge clk)
    $past(rst) |-> !irq);
endmodule

bind uart_reg_front uart_reg_front_chk u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_avail(rx_avail),
  .tx_push(tx_push), .rx_pop(rx_pop), .rx_clr(rx_clr), .tx_clr(tx_clr),
  .divisor(divisor), .line_ctl(line_ctl), .rd_valid(rd_valid), .irq(irq)
);

// File: tb/uart_reg_front_tb.sv
module uart_reg_front_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rd_valid;
  logic [7:0]  tx_data, rx_data, modem_in, line_ctl;
  logic        tx_push, rx_avail, rx_pop, tx_empty, tx_idle;
  logic [3:0]  line_err;
  logic [15:0] divisor;
  logic [4:0]  modem_ctl;
  logic        fifo_en, fifo_deep, rx_clr, tx_clr, irq;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  uart_reg_front u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .tx_data(tx_data), .tx_push(tx_push),
    .rx_data(rx_data), .rx_avail(rx_avail), .rx_pop(rx_pop),
    .tx_empty(tx_empty), .tx_idle(tx_idle), .line_err(line_err),
    .modem_in(modem_in), .divisor(divisor), .line_ctl(line_ctl),
    .modem_ctl(modem_ctl), .fifo_en(fifo_en), .fifo_deep(fifo_deep),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = {24'hABCDEF, d};
    @(posedge clk); #1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // Issues a read; outputs are sampled 1 ns after the capturing edge.
  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic pop);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata; pop = rx_pop;
    if (!rd_valid) begin errs++; checks++; $display("FAIL R12: rd_valid=0 expected=1"); end
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic p;
    chk("R9 divisor", divisor, 16'd1);
    chk("R9 irq", irq, 0);
    chk("R9 line_ctl", line_ctl, 0);
    chk("R9 fifo_en", fifo_en, 0);
    rd(3'd1, d, p); chk("R9 ier", d, 0);
    rd(3'd7, d, p); chk("R9 scratch", d, 0);
  endtask

  task automatic t_scratch_mcr();
    logic [31:0] d; logic p;
    wr(3'd7, 8'hA5); rd(3'd7, d, p); chk("R1 scratch", d, 32'hA5);
    wr(3'd7, 8'h3C); rd(3'd7, d, p); chk("R12 zero-extend", d, 32'h3C);
    wr(3'd4, 8'hFF); rd(3'd4, d, p); chk("R1 mctl read", d, 32'h1F);
    chk("R1 modem_ctl", modem_ctl, 5'h1F);
  endtask

  task automatic t_divisor();
    logic [31:0] d; logic p;
    wr(3'd3, 8'h83);
    chk("R11 lctl open", line_ctl, 8'h83);
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    chk("R2 no push", tx_push, 0);
    rd(3'd0, d, p); chk("R2 div lo read", d, 32'h34); chk("R2 no pop", p, 0);
    rd(3'd1, d, p); chk("R2 div hi read", d, 32'h12);
    wr(3'd3, 8'h03);
    rd(3'd3, d, p); chk("R11 lctl read", d, 32'h03);
  endtask

  task automatic t_tx();
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h5A;
    @(posedge clk); #1;
    chk("R3 push", tx_push, 1); chk("R3 data", tx_data, 8'h5A);
    @(negedge clk); bus_req = 1'b0;
    @(posedge clk); #1;
    chk("R3 push one cycle", tx_push, 0);
    chk("R3 divisor kept", divisor, 16'h1234);
  endtask

  task automatic t_rx();
    logic [31:0] d; logic p;
    rx_avail = 1'b1; rx_data = 8'hC3;
    rd(3'd0, d, p); chk("R4 rx byte", d, 32'hC3); chk("R4 pop", p, 1);
    @(posedge clk); #1; chk("R4 pop one cycle", rx_pop, 0);
    rx_avail = 1'b0;
    rd(3'd0, d, p); chk("R4 empty read", d, 0); chk("R4 no pop", p, 0);
  endtask

  task automatic t_lsr();
    logic [31:0] d; logic p;
    rx_avail = 1'b1; tx_empty = 1'b1; tx_idle = 1'b0; line_err = 4'h0;
    rd(3'd5, d, p); chk("R6 lsr a", d, 32'h21);
    rx_avail = 1'b0; tx_idle = 1'b1; line_err = 4'h5;
    rd(3'd5, d, p); chk("R6 lsr b", d, 32'hEA);
    line_err = 4'h0; tx_empty = 1'b0;
    wr(3'd5, 8'hFF); rd(3'd5, d, p); chk("R8 lsr write ignored", d, 32'h00);
    modem_in = 8'h90;
    wr(3'd6, 8'h0F); rd(3'd6, d, p); chk("R8 msr write ignored", d, 32'h90);
    rd(3'd7, d, p); chk("R8 scratch untouched", d, 32'h3C);
    modem_in = 8'h00;
  endtask

  task automatic t_fifo();
    logic [31:0] d; logic p;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h27;
    @(posedge clk); #1;
    chk("R7 rx_clr", rx_clr, 1); chk("R7 tx_clr", tx_clr, 1);
    chk("R7 fifo_en", fifo_en, 1); chk("R7 fifo_deep", fifo_deep, 1);
    @(negedge clk); bus_req = 1'b0;
    @(posedge clk); #1;
    chk("R7 clr self-clear", {rx_clr, tx_clr}, 0);
    rd(3'd2, d, p); chk("R7 clr bits not stored / R10 none", d, 32'hC1);
  endtask

  task automatic t_irq();
    logic [31:0] d; logic p;
    rx_avail = 1'b1;
    wr(3'd1, 8'hF1);
    rd(3'd1, d, p); chk("R5 ier read", d, 32'h01);
    chk("R5 irq rx", irq, 1);
    wr(3'd1, 8'h0E);
    @(posedge clk); #1; chk("R5 irq masked", irq, 0);
    rx_avail = 1'b0;
    wr(3'd1, 8'h0F);
    line_err = 4'h2; rx_avail = 1'b1; tx_empty = 1'b1; modem_in = 8'h01;
    rd(3'd2, d, p); chk("R10 lerr", d, 32'hC6);
    line_err = 4'h0;
    rd(3'd2, d, p); chk("R10 rxd", d, 32'hC4);
    rx_avail = 1'b0;
    rd(3'd2, d, p); chk("R10 txe", d, 32'hC2);
    tx_empty = 1'b0;
    rd(3'd2, d, p); chk("R10 msts", d, 32'hC0);
    chk("R5 irq modem", irq, 1);
    modem_in = 8'h00;
    rd(3'd2, d, p); chk("R10 none", d, 32'hC1);
    @(posedge clk); #1; chk("R5 irq idle", irq, 0);
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_data = '0; rx_avail = 1'b0; tx_empty = 1'b0; tx_idle = 1'b0;
    line_err = '0; modem_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_scratch_mcr();
    t_divisor();
    t_tx();
    t_rx();
    t_lsr();
    t_fifo();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule